// File: doc/BRIEF.md
# Floating-point exception flag accumulator

This block sits beside a floating-point unit and collects the per-operation status the unit reports into eight sticky architectural flags. Each operation reports a cause vector of thirteen detailed bits. Several of these bits describe why an operation was invalid. The block folds them into a small set of flags: invalid, signalling NaN, quiet NaN, overflow, underflow, infinity, divide-by-zero and inexact. It ORs the result into the held flag field. After every enabled operation whose flags come out nonzero, it issues a one-cycle exception request. That request carries the program counter of the operation that caused it.

A single enable input stands for the global exception-enable bit of the control/status register. While the enable is low, reported status is ignored completely. The flags clear only through a software write port, which loads the whole field. A parameter selects what happens when a software write and an enabled operation land in the same cycle: either the written value wins, or the new causes are merged into it.

Top module: `fpx_flag_accum`

## Requirements
- R1: After reset `flags_o` is 8'h00, `exc_req_o` is 0 and `exc_addr_o` is 0.
- R2: When `op_valid_i` is low or `exc_en_i` is low, the cause input has no effect. `flags_o` keeps its value and `exc_req_o` is 0 in the following cycle.
- R3: Flag field bit positions are: [0] invalid, [1] signalling NaN, [2] quiet NaN, [3] overflow, [4] underflow, [5] infinity, [6] divide-by-zero, [7] inexact. Any of the cause bits [0] signalling NaN, [1] quiet NaN, [2] inf-inf, [3] inf/inf, [4] 0/0, [5] inf*0, [6] bad conversion, [7] bad compare and [8] bad square root sets the invalid flag.
- R4: Cause bit [0] sets flag [1] and cause bit [1] sets flag [2]. Each also sets the invalid flag.
- R5: Cause bit [9] sets the overflow flag [3] and cause bit [10] sets the underflow flag [4]. Several causes in one operation set all of their flags.
- R6: Cause bit [2] or cause bit [3] sets the infinity flag [5].
- R7: Cause bit [11] sets the divide-by-zero flag [6] and cause bit [12] sets the inexact flag [7]. Neither one sets invalid.
- R8: Flags are sticky. An enabled operation only ORs new flags into the held value, so a set flag stays set until a software write.
- R9: An enabled operation whose flags after the update are nonzero raises `exc_req_o` in the next cycle. `exc_req_o` lasts one cycle unless another such operation follows. `exc_addr_o` then equals the `prev_pc_i` presented with that operation.
- R10: An enabled operation with an all-zero cause and all-zero held flags raises no request.
- R11: A software write loads `sw_wr_flags_i` into the flags in the next cycle. When `WRITE_WINS` is 1 and an enabled operation arrives in the same cycle, the written value alone is stored. When `WRITE_WINS` is 0, the operation's flags are ORed into it. In both cases the request follows R9, using the held flags and the operation's flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | An operation's cause vector is valid this cycle |
| op_cause_i | input | 13 | Detailed cause bits of the operation |
| exc_en_i | input | 1 | Global exception/flag-update enable |
| prev_pc_i | input | PC_W | Program counter of the reporting operation |
| sw_wr_en_i | input | 1 | Software load of the flag field |
| sw_wr_flags_i | input | 8 | Value loaded by a software write |
| flags_o | output | 8 | Held sticky flag field |
| exc_req_o | output | 1 | Floating-point exception request pulse |
| exc_addr_o | output | PC_W | Faulting address belonging to the request |

## Verification
The bench builds the block with its defaults: a 32-bit program counter and `WRITE_WINS` set to 1. With these values, every cause bit can be driven from a cleared flag field, and the request can be checked together with a distinct full-width address on each vector. Same-cycle collisions between a software write and an operation fall into the write-wins variant. The merging variant is covered only by the assertions and by elaboration.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

   localparam int CAUSE_W = 13;
   localparam int FLAG_W  = 8;

   // cause vector bit positions
   localparam int C_SNAN  = 0;
   localparam int C_QNAN  = 1;
   localparam int C_ISI   = 2;
   localparam int C_IDI   = 3;
   localparam int C_ZDZ   = 4;
   localparam int C_IMZ   = 5;
   localparam int C_CVT   = 6;
   localparam int C_CMP   = 7;
   localparam int C_SQRT  = 8;
   localparam int C_OVF   = 9;
   localparam int C_UNF   = 10;
   localparam int C_DZ    = 11;
   localparam int C_INX   = 12;

   // flag field bit positions
   localparam int F_INV   = 0;
   localparam int F_SNAN  = 1;
   localparam int F_QNAN  = 2;
   localparam int F_OVF   = 3;
   localparam int F_UNF   = 4;
   localparam int F_INF   = 5;
   localparam int F_DZ    = 6;
   localparam int F_INX   = 7;

   localparam logic [CAUSE_W-1:0] INV_CAUSE_MASK = 13'h01FF;
   localparam logic [CAUSE_W-1:0] INF_CAUSE_MASK = 13'h000C;

   typedef logic [CAUSE_W-1:0] cause_vec_t;
   typedef logic [FLAG_W-1:0]  flag_vec_t;

endpackage

// File: rtl/fpx_cause_map.sv
module fpx_cause_map
   import fpx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  cause_vec_t cause_i,
   output flag_vec_t  flags_o
);

   always_comb begin
      flags_o         = '0;
      flags_o[F_INV]  = |(cause_i & INV_CAUSE_MASK);
      flags_o[F_SNAN] = cause_i[C_SNAN];
      flags_o[F_QNAN] = cause_i[C_QNAN];
      flags_o[F_OVF]  = cause_i[C_OVF];
      flags_o[F_UNF]  = cause_i[C_UNF];
      flags_o[F_INF]  = |(cause_i & INF_CAUSE_MASK);
      flags_o[F_DZ]   = cause_i[C_DZ];
      flags_o[F_INX]  = cause_i[C_INX];
   end

   // every NaN cause also marks the operation invalid
   p_nan_is_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_i[C_SNAN] || cause_i[C_QNAN]) |-> flags_o[F_INV]);

   // infinity causes are a subset of invalid causes
   p_inf_is_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[F_INF] |-> flags_o[F_INV]);

   // divide-by-zero and inexact never imply invalid on their own
   p_dz_inx_not_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_i & INV_CAUSE_MASK) == '0) |-> !flags_o[F_INV]);

endmodule

// File: rtl/fpx_flag_store.sv
module fpx_flag_store
   import fpx_pkg::*;
#(
   parameter bit WRITE_WINS = 1'b1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      upd_en_i,
   input  flag_vec_t upd_flags_i,
   input  logic      wr_en_i,
   input  flag_vec_t wr_flags_i,
   output flag_vec_t flags_q_o
);

   flag_vec_t flags_q;
   flag_vec_t flags_d;
   flag_vec_t upd_gated;

   assign upd_gated = upd_en_i ? upd_flags_i : '0;

   generate
      if (WRITE_WINS) begin : g_write_wins
         always_comb begin
            if (wr_en_i) flags_d = wr_flags_i;
            else         flags_d = flags_q | upd_gated;
         end
      end else begin : g_write_merge
         always_comb begin
            if (wr_en_i) flags_d = wr_flags_i | upd_gated;
            else         flags_d = flags_q | upd_gated;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags_q_o = flags_q;

   // without a software write, no set flag can ever drop
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   // idle cycles leave the field untouched
   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && !upd_en_i) |=> $stable(flags_q));

   // a lone software write loads its value exactly
   p_write_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !upd_en_i) |=> (flags_q == $past(wr_flags_i)));

endmodule

// File: rtl/fpx_exc_gen.sv
module fpx_exc_gen
   import fpx_pkg::*;
#(
   parameter int PC_W = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire_i,
   input  flag_vec_t       held_flags_i,
   input  flag_vec_t       new_flags_i,
   input  logic [PC_W-1:0] pc_i,
   output logic            req_o,
   output logic [PC_W-1:0] addr_o
);

   logic            req_q;
   logic [PC_W-1:0] addr_q;
   logic            any_set;

   assign any_set = |(held_flags_i | new_flags_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         req_q <= fire_i && any_set;
         if (fire_i && any_set) addr_q <= pc_i;
      end
   end

   assign req_o  = req_q;
   assign addr_o = addr_q;

   // the reported address belongs to the operation one cycle back
   p_addr_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> (addr_q == $past(pc_i)));

   // the address register only moves along with a request
   p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_q |-> $stable(addr_q));

endmodule

// File: rtl/fpx_flag_accum.sv
module fpx_flag_accum
   import fpx_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter bit WRITE_WINS = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid_i,
   input  logic [CAUSE_W-1:0]   op_cause_i,
   input  logic                 exc_en_i,
   input  logic [PC_W-1:0]      prev_pc_i,
   input  logic                 sw_wr_en_i,
   input  logic [FLAG_W-1:0]    sw_wr_flags_i,
   output logic [FLAG_W-1:0]    flags_o,
   output logic                 exc_req_o,
   output logic [PC_W-1:0]      exc_addr_o
);

   localparam int MIN_PC_W = 2;

   generate
      if (PC_W < MIN_PC_W) begin : g_bad_pc_w
         $error("fpx_flag_accum: PC_W must be at least 2");
      end
   endgenerate

   flag_vec_t op_flags;
   flag_vec_t held_flags;
   logic      upd_fire;

   assign upd_fire = op_valid_i && exc_en_i;

   fpx_cause_map u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .cause_i (op_cause_i),
      .flags_o (op_flags)
   );

   fpx_flag_store #(
      .WRITE_WINS (WRITE_WINS)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_en_i    (upd_fire),
      .upd_flags_i (op_flags),
      .wr_en_i     (sw_wr_en_i),
      .wr_flags_i  (sw_wr_flags_i),
      .flags_q_o   (held_flags)
   );

   fpx_exc_gen #(
      .PC_W (PC_W)
   ) u_exc (
      .clk          (clk),
      .rst_n        (rst_n),
      .fire_i       (upd_fire),
      .held_flags_i (held_flags),
      .new_flags_i  (op_flags),
      .pc_i         (prev_pc_i),
      .req_o        (exc_req_o),
      .addr_o       (exc_addr_o)
   );

   assign flags_o = held_flags;

   // disabled or absent operations never request an exception
   p_no_req_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid_i && exc_en_i) |=> !exc_req_o);

   // enabled operation with something set gives a request next cycle
   p_req_on_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && exc_en_i && ((flags_o != '0) || (op_cause_i != '0)))
      |=> exc_req_o);

   // clean operation on clean flags stays quiet
   p_no_req_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && exc_en_i && (flags_o == '0) && (op_cause_i == '0))
      |=> !exc_req_o);

   // a request always follows a set field, unless software rewrote it
   p_req_implies_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req_o && !$past(sw_wr_en_i)) |-> (flags_o != '0));

endmodule

// File: tb/fpx_flag_accum_tb.sv
module fpx_flag_accum_tb_top;

   localparam int PC_W   = 32;
   localparam int N_VEC  = 15;

   // {cause[12:0], expected flags[7:0], expected request}
   localparam logic [21:0] VEC_TAB [N_VEC] = '{
      {13'h0001, 8'h03, 1'b1},
      {13'h0002, 8'h05, 1'b1},
      {13'h0004, 8'h21, 1'b1},
      {13'h0008, 8'h21, 1'b1},
      {13'h0010, 8'h01, 1'b1},
      {13'h0020, 8'h01, 1'b1},
      {13'h0040, 8'h01, 1'b1},
      {13'h0080, 8'h01, 1'b1},
      {13'h0100, 8'h01, 1'b1},
      {13'h0200, 8'h08, 1'b1},
      {13'h0400, 8'h10, 1'b1},
      {13'h0800, 8'h40, 1'b1},
      {13'h1000, 8'h80, 1'b1},
      {13'h1200, 8'h88, 1'b1},
      {13'h0000, 8'h00, 1'b0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            op_valid = 1'b0;
   logic [12:0]     op_cause = '0;
   logic            exc_en = 1'b0;
   logic [PC_W-1:0] prev_pc = '0;
   logic            sw_wr_en = 1'b0;
   logic [7:0]      sw_wr_flags = '0;
   logic [7:0]      flags;
   logic            exc_req;
   logic [PC_W-1:0] exc_addr;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   fpx_flag_accum #(.PC_W(PC_W), .WRITE_WINS(1'b1)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .op_valid_i    (op_valid),
      .op_cause_i    (op_cause),
      .exc_en_i      (exc_en),
      .prev_pc_i     (prev_pc),
      .sw_wr_en_i    (sw_wr_en),
      .sw_wr_flags_i (sw_wr_flags),
      .flags_o       (flags),
      .exc_req_o     (exc_req),
      .exc_addr_o    (exc_addr)
   );

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle of stimulus; returns at the next falling edge with inputs idle
   task automatic step(input logic v, input logic [12:0] c, input logic en,
                       input logic [PC_W-1:0] pc, input logic wr,
                       input logic [7:0] wd);
      @(negedge clk);
      op_valid = v; op_cause = c; exc_en = en; prev_pc = pc;
      sw_wr_en = wr; sw_wr_flags = wd;
      @(negedge clk);
      op_valid = 1'b0; op_cause = '0; sw_wr_en = 1'b0; sw_wr_flags = '0;
   endtask

   function automatic string vec_tag(input int i);
      if (i < 2)        return "R4";
      else if (i < 4)   return "R6";
      else if (i < 9)   return "R3";
      else if (i < 11)  return "R5";
      else if (i < 13)  return "R7";
      else if (i == 13) return "R5";
      else              return "R10";
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 flags", 32'(flags), 32'h00);
      check("R1 req", 32'(exc_req), 32'h0);
      check("R1 addr", exc_addr, 32'h0);

      exc_en = 1'b1;
      // table walk: clear, apply, check flags, request, address, pulse end
      for (int i = 0; i < N_VEC; i++) begin
         step(1'b0, '0, 1'b1, '0, 1'b1, 8'h00);
         step(1'b1, VEC_TAB[i][21:9], 1'b1, 32'h1000_0000 + 32'(i * 4),
              1'b0, 8'h00);
         check({vec_tag(i), " flags"}, 32'(flags), 32'(VEC_TAB[i][8:1]));
         check(VEC_TAB[i][0] ? "R9 req" : "R10 req", 32'(exc_req),
               32'(VEC_TAB[i][0]));
         if (VEC_TAB[i][0])
            check("R9 addr", exc_addr, 32'h1000_0000 + 32'(i * 4));
         @(negedge clk);
         check("R9 pulse end", 32'(exc_req), 32'h0);
      end

      // R2: disabled enable ignores causes, held flags survive
      step(1'b0, '0, 1'b1, '0, 1'b1, 8'h40);
      step(1'b1, 13'h0200, 1'b0, 32'hDEAD_0000, 1'b0, 8'h00);
      check("R2 flags disabled", 32'(flags), 32'h40);
      check("R2 req disabled", 32'(exc_req), 32'h0);
      check("R2 addr kept", exc_addr, 32'h1000_0034);
      exc_en = 1'b1;
      // R2: no valid strobe ignores causes
      step(1'b0, 13'h1FFF, 1'b1, 32'hBEEF_0000, 1'b0, 8'h00);
      check("R2 flags no valid", 32'(flags), 32'h40);
      check("R2 req no valid", 32'(exc_req), 32'h0);

      // R8: sticky accumulation
      step(1'b0, '0, 1'b1, '0, 1'b1, 8'h00);
      step(1'b1, 13'h0200, 1'b1, 32'h2000, 1'b0, 8'h00);
      check("R8 first", 32'(flags), 32'h08);
      step(1'b1, 13'h1000, 1'b1, 32'h2004, 1'b0, 8'h00);
      check("R8 accumulate", 32'(flags), 32'h88);
      step(1'b1, 13'h0000, 1'b1, 32'h2008, 1'b0, 8'h00);
      check("R8 held", 32'(flags), 32'h88);
      check("R9 req on held flags", 32'(exc_req), 32'h1);
      check("R9 addr on held flags", exc_addr, 32'h2008);

      // R9: back-to-back operations keep the request high with fresh address
      step(1'b1, 13'h0800, 1'b1, 32'h3000, 1'b0, 8'h00);
      check("R9 b2b req", 32'(exc_req), 32'h1);
      check("R9 b2b addr", exc_addr, 32'h3000);

      // R11: software write replaces and clears
      step(1'b0, '0, 1'b1, '0, 1'b1, 8'hFF);
      check("R11 load ff", 32'(flags), 32'hFF);
      check("R11 no req on write", 32'(exc_req), 32'h0);
      step(1'b0, '0, 1'b1, '0, 1'b1, 8'h00);
      check("R11 clear", 32'(flags), 32'h00);
      // R11: collision, write value wins
      step(1'b1, 13'h0800, 1'b1, 32'h4000, 1'b1, 8'h01);
      check("R11 collision flags", 32'(flags), 32'h01);
      check("R11 collision req", 32'(exc_req), 32'h1);
      check("R11 collision addr", exc_addr, 32'h4000);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule